// File: doc/BRIEF.md
# Byte-Serial Multicycle 16-bit Processor Core

This block is a small multicycle processor. It has eight 16-bit general registers and runs a byte-oriented instruction set from a 64 KB byte-addressed memory. Each instruction starts with an opcode byte. Register-index and little-endian 16-bit operand bytes follow it, so an instruction is one to four bytes long. The core fetches one byte per cycle through a synchronous single-port memory, which returns read data one clock after the address is presented. It collects the operand bytes it needs, then executes: immediate load, add, AND, OR and XOR, register complement, a two-byte store, an absolute jump, a jump on a zero register, subroutine call and return through a memory stack that grows downward, port input and output, and halt.

Input data arrives on a valid/ready port. The core raises `in_ready` only while an input instruction is waiting. A word moves on a clock edge where both `in_valid` and `in_ready` are high. Until that edge the core stalls and holds every other output steady. The producer may raise `in_valid` early and must hold `in_data` until the transfer edge. The output port has no back-pressure. Each output instruction drives `out_data` and raises `out_valid` for exactly one cycle, and the consumer must take the word in that cycle.

Top module: `bytecpu16`

## Requirements
- R1: Reset clears the registers to 0, sets the program counter to 0x0000 and the stack pointer to 0x10000, and clears `halted`. The first fetch after reset reads address 0x0000, and no write occurs.
- R2: Load (0x01) and add (0x02) are 4 bytes: opcode, register index (low 3 bits used), immediate low byte, immediate high byte. Load puts the immediate in the register. Add writes the sum modulo 2^16 back to the register.
- R3: AND (0x06), OR (0x07) and XOR (0x08) have the same 4-byte form and write the register combined with the immediate back to the register. NOT (0x09) is 2 bytes (opcode, register) and replaces the register with its complement.
- R4: After any non-control instruction the next fetch is at the byte after it. Lengths are: 1 byte for 0x00, 0x0B, 0xFF and every undefined code; 2 bytes for 0x09, 0x0C, 0x0D; 3 bytes for 0x04, 0x0A; 4 bytes for 0x01, 0x02, 0x03, 0x05, 0x06, 0x07, 0x08.
- R5: Store (0x03; opcode, register, address low, address high) writes the register low byte at the address and the high byte at the address plus one, on two consecutive cycles. It writes no other byte.
- R6: Jump (0x04; opcode, address low, address high) continues at the address. Jump-if-zero (0x05; opcode, register, address low, address high) continues at the address when the register is 0 and otherwise at the next instruction.
- R7: Call (0x0A, same form as jump) lowers the stack pointer by 2, writes the return address (call address + 3) there low byte first, and jumps. Return (0x0B) reads two bytes at the stack pointer into the program counter and raises the stack pointer by 2. The first call from reset writes 0xFFFE and 0xFFFF, and calls nest.
- R8: Input (0x0C; opcode, register) keeps `in_ready` high and waits, with no register change and no output, until a cycle with `in_valid` high. It then loads `in_data` into the register.
- R9: Output (0x0D; opcode, register) presents the register on `out_data` with `out_valid` high for exactly one cycle per instruction.
- R10: Halt (0xFF) sets `halted`, which stays set until reset. After that no memory write and no output occurs.
- R11: An undefined opcode changes no register and no memory and acts as a 1-byte no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Byte address for the memory |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable for `mem_wdata` at `mem_addr` |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| in_data | input | 16 | Input port word |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Core is waiting for an input word |
| out_data | output | 16 | Output port word |
| out_valid | output | 1 | One-cycle strobe marking `out_data` |
| halted | output | 1 | Core has executed halt |

## Verification
Nested subroutine calls are the hardest case to reach from the ports. Two frames must sit at the very top of memory, at 0xFFFC and 0xFFFE, and each return must come back to the right caller. The bench reaches this with a two-level call program and then reads the stack bytes back from its memory model. A second hard case is an input stall that lasts many cycles. The bench withholds `in_valid` for a counted number of waiting cycles and then checks that the stall length and the loaded word match, followed by an input whose data is already offered. Every arithmetic and logic opcode is also swept over all eight registers and a grid of operand patterns, including the add wrap-around.

// File: rtl/bytecpu_pkg.sv
package bytecpu_pkg;
  localparam int WORD_W = 16;

  localparam logic [7:0] OPC_NOP   = 8'h00;
  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_ADD   = 8'h02;
  localparam logic [7:0] OPC_STORE = 8'h03;
  localparam logic [7:0] OPC_JMP   = 8'h04;
  localparam logic [7:0] OPC_JZ    = 8'h05;
  localparam logic [7:0] OPC_AND   = 8'h06;
  localparam logic [7:0] OPC_OR    = 8'h07;
  localparam logic [7:0] OPC_XOR   = 8'h08;
  localparam logic [7:0] OPC_NOT   = 8'h09;
  localparam logic [7:0] OPC_CALL  = 8'h0A;
  localparam logic [7:0] OPC_RET   = 8'h0B;
  localparam logic [7:0] OPC_IN    = 8'h0C;
  localparam logic [7:0] OPC_OUT   = 8'h0D;
  localparam logic [7:0] OPC_HALT  = 8'hFF;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_OPND, ST_EXEC,
    ST_WLO, ST_WHI, ST_PUSHLO, ST_PUSHHI,
    ST_POPA, ST_POPB, ST_POPC, ST_INWAIT, ST_STOP
  } state_e;

  // total instruction length in bytes, opcode included
  function automatic logic [2:0] insn_bytes(input logic [7:0] opc);
    case (opc)
      OPC_LOAD, OPC_ADD, OPC_STORE, OPC_JZ,
      OPC_AND, OPC_OR, OPC_XOR:           insn_bytes = 3'd4;
      OPC_JMP, OPC_CALL:                  insn_bytes = 3'd3;
      OPC_NOT, OPC_IN, OPC_OUT:           insn_bytes = 3'd2;
      default:                            insn_bytes = 3'd1;
    endcase
  endfunction

  function automatic logic writes_reg(input logic [7:0] opc);
    case (opc)
      OPC_LOAD, OPC_ADD, OPC_AND, OPC_OR,
      OPC_XOR, OPC_NOT:                   writes_reg = 1'b1;
      default:                            writes_reg = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bytecpu_alu.sv
module bytecpu_alu
  import bytecpu_pkg::*;
(
  input  logic [7:0]        opc,
  input  logic [WORD_W-1:0] reg_val,
  input  logic [WORD_W-1:0] imm,
  output logic [WORD_W-1:0] result
);
  always_comb begin
    case (opc)
      OPC_LOAD: result = imm;
      OPC_ADD:  result = reg_val + imm;
      OPC_AND:  result = reg_val & imm;
      OPC_OR:   result = reg_val | imm;
      OPC_XOR:  result = reg_val ^ imm;
      OPC_NOT:  result = ~reg_val;
      default:  result = reg_val;
    endcase
  end
endmodule

// File: rtl/bytecpu_regs.sv
module bytecpu_regs #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [W-1:0]            rdata
);
  localparam int IW = $clog2(NREG);

  logic [W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q[g] <= '0;
      else if (we && waddr == IW'(g))     q[g] <= wdata;
    end
  end

  assign rdata = q[raddr];
endmodule

// File: rtl/bytecpu16.sv
module bytecpu16
  import bytecpu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  localparam int RIW = $clog2(NREG);
  localparam logic [AW:0] SP_TOP = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] SP_STEP = (AW+1)'(2);

  state_e          st;
  logic [AW-1:0]   pc;
  logic [AW:0]     sp;
  logic [7:0]      opc, ob1, ob2, ob3, pop_lo;
  logic [1:0]      cnt;

  logic [2:0]        len, len_new;
  logic [WORD_W-1:0] rd_val, alu_y, imm, rf_wdata, ret_addr;
  logic [AW-1:0]     jmp_tgt, jz_tgt, sp_a;
  logic              rf_we;

  assign len      = insn_bytes(opc);
  assign len_new  = insn_bytes(mem_rdata);
  assign imm      = {ob3, ob2};
  assign jmp_tgt  = AW'({ob2, ob1});
  assign jz_tgt   = AW'({ob3, ob2});
  assign ret_addr = WORD_W'(pc + AW'(3));
  assign sp_a     = sp[AW-1:0];

  assign rf_we    = (st == ST_EXEC && writes_reg(opc)) || (st == ST_INWAIT && in_valid);
  assign rf_wdata = (st == ST_INWAIT) ? in_data : alu_y;
  assign in_ready = (st == ST_INWAIT);

  bytecpu_regs #(.NREG(NREG), .W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(ob1[RIW-1:0]),
    .wdata(rf_wdata), .raddr(ob1[RIW-1:0]), .rdata(rd_val)
  );

  bytecpu_alu u_alu (.opc(opc), .reg_val(rd_val), .imm(imm), .result(alu_y));

  // address, data and strobe for the byte port, chosen by state
  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    case (st)
      ST_DECODE: mem_addr = pc + AW'(1);
      ST_OPND:   mem_addr = pc + AW'(cnt) + AW'(1);
      ST_WLO:    begin mem_addr = jz_tgt;          mem_we = 1'b1; mem_wdata = rd_val[7:0];   end
      ST_WHI:    begin mem_addr = jz_tgt + AW'(1); mem_we = 1'b1; mem_wdata = rd_val[15:8];  end
      ST_PUSHLO: begin mem_addr = sp_a;            mem_we = 1'b1; mem_wdata = ret_addr[7:0]; end
      ST_PUSHHI: begin mem_addr = sp_a + AW'(1);   mem_we = 1'b1; mem_wdata = ret_addr[15:8];end
      ST_POPA:   mem_addr = sp_a;
      ST_POPB:   mem_addr = sp_a + AW'(1);
      default:   mem_addr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_FETCH; pc <= '0; sp <= SP_TOP; halted <= 1'b0;
      opc <= '0; ob1 <= '0; ob2 <= '0; ob3 <= '0; pop_lo <= '0; cnt <= '0;
      out_data <= '0; out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_FETCH: st <= ST_DECODE;
        ST_DECODE: begin
          opc <= mem_rdata;
          if (len_new == 3'd1) begin
            if (mem_rdata == OPC_HALT)     begin halted <= 1'b1; st <= ST_STOP; end
            else if (mem_rdata == OPC_RET) st <= ST_POPA;
            else                           begin pc <= pc + AW'(1); st <= ST_FETCH; end
          end else begin
            cnt <= 2'd1;
            st  <= ST_OPND;
          end
        end
        ST_OPND: begin
          case (cnt)
            2'd1:    ob1 <= mem_rdata;
            2'd2:    ob2 <= mem_rdata;
            default: ob3 <= mem_rdata;
          endcase
          if ({1'b0, cnt} == len - 3'd1) st <= ST_EXEC;
          else                           cnt <= cnt + 2'd1;
        end
        ST_EXEC: begin
          st <= ST_FETCH;
          pc <= pc + AW'(len);
          case (opc)
            OPC_STORE: begin pc <= pc; st <= ST_WLO; end
            OPC_JMP:   pc <= jmp_tgt;
            OPC_JZ:    if (rd_val == '0) pc <= jz_tgt;
            OPC_CALL:  begin pc <= pc; sp <= sp - SP_STEP; st <= ST_PUSHLO; end
            OPC_IN:    begin pc <= pc; st <= ST_INWAIT; end
            OPC_OUT:   begin out_data <= rd_val; out_valid <= 1'b1; end
            default:   ;
          endcase
        end
        ST_WLO:    st <= ST_WHI;
        ST_WHI:    begin pc <= pc + AW'(4); st <= ST_FETCH; end
        ST_PUSHLO: st <= ST_PUSHHI;
        ST_PUSHHI: begin pc <= jmp_tgt; st <= ST_FETCH; end
        ST_POPA:   st <= ST_POPB;
        ST_POPB:   begin pop_lo <= mem_rdata; st <= ST_POPC; end
        ST_POPC:   begin pc <= AW'({mem_rdata, pop_lo}); sp <= sp + SP_STEP; st <= ST_FETCH; end
        ST_INWAIT: if (in_valid) begin pc <= pc + AW'(2); st <= ST_FETCH; end
        default:   st <= ST_STOP;
      endcase
    end
  end

  // R1: the first cycle out of reset fetches address zero, nothing written
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_addr == '0 && !mem_we && !halted));

  // R5 / R7: a write burst is exactly two bytes at consecutive addresses
  p_write_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == $past(mem_addr) + AW'(1)));
  p_write_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |=> !mem_we);

  // R7: stack pointer never rises above its reset value
  p_sp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_TOP);

  // R8: a wait for input persists until the word is offered
  p_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (in_ready && !out_valid && !mem_we));

  // R9: the output strobe never lasts two cycles
  p_out_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10: halt is sticky and silent
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !out_valid && !in_ready));
endmodule

// File: tb/bytecpu16_test.sv
module bytecpu16_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] in_data, out_data;
  logic        in_valid, in_ready, out_valid, halted;

  bytecpu16 uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .halted(halted)
  );

  // sparse memory model: low 1 KB plus top 256 bytes
  logic [7:0]  mlo [0:1023];
  logic [7:0]  mhi [0:255];
  logic        tb_clr, tb_we;
  logic [15:0] tb_addr;
  logic [7:0]  tb_data;

  function automatic logic [7:0] mread(input logic [15:0] a);
    if (a < 16'h0400)      return mlo[a[9:0]];
    else if (a >= 16'hFF00) return mhi[a[7:0]];
    else                    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (tb_clr) begin
      for (int i = 0; i < 1024; i++) mlo[i] <= 8'h00;
      for (int i = 0; i < 256; i++)  mhi[i] <= 8'h00;
    end else if (tb_we) begin
      if (tb_addr < 16'h0400) mlo[tb_addr[9:0]] <= tb_data;
      else if (tb_addr >= 16'hFF00) mhi[tb_addr[7:0]] <= tb_data;
    end else if (mem_we) begin
      if (mem_addr < 16'h0400) mlo[mem_addr[9:0]] <= mem_wdata;
      else if (mem_addr >= 16'hFF00) mhi[mem_addr[7:0]] <= mem_wdata;
    end
    mem_rdata <= mread(mem_addr);
  end

  int n_tests = 0, n_fail = 0;
  logic [15:0] outs [0:15];
  int nouts, stall, bad, hc;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    tb_addr = a; tb_data = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put4(input logic [15:0] a, input logic [7:0] o, input logic [7:0] r, input logic [15:0] v);
    put(a, o); put(a + 16'd1, r); put(a + 16'd2, v[7:0]); put(a + 16'd3, v[15:8]);
  endtask

  task automatic put3(input logic [15:0] a, input logic [7:0] o, input logic [15:0] v);
    put(a, o); put(a + 16'd1, v[7:0]); put(a + 16'd2, v[15:8]);
  endtask

  task automatic put2(input logic [15:0] a, input logic [7:0] o, input logic [7:0] r);
    put(a, o); put(a + 16'd1, r);
  endtask

  task automatic run(input int in_delay);
    int waitc;
    nouts = 0; stall = 0; bad = 0; hc = 0; waitc = 0;
    rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (nouts < 16) outs[nouts] = out_data;
        nouts++;
      end
      if (in_ready) begin
        if (waitc >= in_delay) in_valid = 1'b1;
        else begin in_valid = 1'b0; stall++; end
        waitc++;
      end else in_valid = 1'b0;
      if (halted) begin
        hc++;
        if (mem_we || out_valid || in_ready) bad++;
        if (hc >= 8) break;
      end
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] expect_alu(input int oi, input logic [15:0] a, input logic [15:0] b);
    case (oi)
      0: return b;
      1: return 16'((32'(a) + 32'(b)) % 65536);
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return 16'hFFFF - a;
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  opl [0:5];
    logic [15:0] av [0:3];
    logic [15:0] bv [0:3];
    opl[0] = 8'h01; opl[1] = 8'h02; opl[2] = 8'h06;
    opl[3] = 8'h07; opl[4] = 8'h08; opl[5] = 8'h09;
    av[0] = 16'h0000; av[1] = 16'hFFFF; av[2] = 16'h0F0F; av[3] = 16'hABCD;
    bv[0] = 16'h00FF; bv[1] = 16'h0001; bv[2] = 16'hFFFF; bv[3] = 16'h3333;

    rst_n = 1'b0; in_valid = 1'b0; in_data = 16'h0000;
    tb_we = 1'b0; tb_addr = '0; tb_data = '0; tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0; @(negedge clk);

    // R1: reset state at the ports
    check(!halted && !mem_we && !out_valid && !in_ready, "R1 reset outputs",
          {halted, mem_we, out_valid, in_ready}, 4'b0000);
    check(mem_addr == 16'h0000, "R1 fetch address", mem_addr, 16'h0000);

    // R2 R3: sweep all registers, operations and operand grid
    for (int r = 0; r < 8; r++)
      for (int oi = 0; oi < 6; oi++)
        for (int ia = 0; ia < 4; ia++)
          for (int ib = 0; ib < 4; ib++) begin
            logic [15:0] e;
            put4(16'h0000, 8'h01, 8'(r), av[ia]);
            if (oi == 5) begin
              put2(16'h0004, 8'h09, 8'(r));
              put2(16'h0006, 8'h0D, 8'(r));
              put(16'h0008, 8'hFF);
            end else begin
              put4(16'h0004, opl[oi], 8'(r), bv[ib]);
              put2(16'h0008, 8'h0D, 8'(r));
              put(16'h000A, 8'hFF);
            end
            run(0);
            e = expect_alu(oi, av[ia], bv[ib]);
            if (oi < 2) check(nouts == 1 && outs[0] == e, "R2 load/add", outs[0], e);
            else        check(nouts == 1 && outs[0] == e, "R3 logic op", outs[0], e);
          end

    // R4 R11: lengths with no-op and undefined codes ahead of a load
    put(16'h0000, 8'h00); put(16'h0001, 8'h42); put(16'h0002, 8'h0E);
    put4(16'h0003, 8'h01, 8'h01, 16'h1234);
    put2(16'h0007, 8'h09, 8'h01);
    put2(16'h0009, 8'h0D, 8'h01);
    put(16'h000B, 8'hFF);
    run(0);
    check(nouts == 1 && outs[0] == 16'hEDCB, "R4 R11 lengths and undefined opcode", outs[0], 16'hEDCB);

    // R5: store two bytes, neighbours untouched
    put4(16'h0000, 8'h01, 8'h02, 16'hBEEF);
    put4(16'h0004, 8'h03, 8'h02, 16'h0300);
    put(16'h0008, 8'hFF);
    run(0);
    check(mlo[10'h300] == 8'hEF && mlo[10'h301] == 8'hBE, "R5 store bytes",
          {mlo[10'h300], mlo[10'h301]}, 16'hEFBE);
    check(mlo[10'h2FF] == 8'h00 && mlo[10'h302] == 8'h00, "R5 store neighbours",
          {mlo[10'h2FF], mlo[10'h302]}, 16'h0000);

    // R6: unconditional jump skips the fall-through output
    put3(16'h0000, 8'h04, 16'h0100);
    put2(16'h0003, 8'h0D, 8'h00);
    put(16'h0005, 8'hFF);
    put4(16'h0100, 8'h01, 8'h03, 16'h55AA);
    put2(16'h0104, 8'h0D, 8'h03);
    put(16'h0106, 8'hFF);
    run(0);
    check(nouts == 1 && outs[0] == 16'h55AA, "R6 jump", outs[0], 16'h55AA);

    // R6: jump-if-zero not taken then taken
    put4(16'h0000, 8'h01, 8'h04, 16'h0007);
    put4(16'h0004, 8'h05, 8'h04, 16'h0200);
    put2(16'h0008, 8'h0D, 8'h04);
    put4(16'h000A, 8'h05, 8'h05, 16'h0180);
    put2(16'h000E, 8'h0D, 8'h04);
    put4(16'h0180, 8'h01, 8'h04, 16'h0009);
    put2(16'h0184, 8'h0D, 8'h04);
    put(16'h0186, 8'hFF);
    run(0);
    check(nouts == 2, "R6 jz output count", nouts, 2);
    check(outs[0] == 16'h0007 && outs[1] == 16'h0009, "R6 jz path", {outs[0], outs[1]}, 32'h00070009);

    // R7: single call and return
    put3(16'h0000, 8'h0A, 16'h0100);
    put2(16'h0003, 8'h0D, 8'h06);
    put(16'h0005, 8'hFF);
    put4(16'h0100, 8'h01, 8'h06, 16'h1357);
    put(16'h0104, 8'h0B);
    run(0);
    check(nouts == 1 && outs[0] == 16'h1357, "R7 call/return", outs[0], 16'h1357);
    check(mhi[8'hFE] == 8'h03 && mhi[8'hFF] == 8'h00, "R7 stack top bytes",
          {mhi[8'hFE], mhi[8'hFF]}, 16'h0300);

    // R7: nested calls
    put3(16'h0100, 8'h0A, 16'h0140);
    put4(16'h0103, 8'h02, 8'h06, 16'h0001);
    put(16'h0107, 8'h0B);
    put4(16'h0140, 8'h01, 8'h06, 16'h0010);
    put(16'h0144, 8'h0B);
    run(0);
    check(nouts == 1 && outs[0] == 16'h0011, "R7 nested result", outs[0], 16'h0011);
    check(mhi[8'hFC] == 8'h03 && mhi[8'hFD] == 8'h01, "R7 inner frame",
          {mhi[8'hFC], mhi[8'hFD]}, 16'h0301);

    // R8: input stalls, then loads the offered word
    in_data = 16'hA5C3;
    put2(16'h0000, 8'h0C, 8'h02);
    put2(16'h0002, 8'h0D, 8'h02);
    put2(16'h0004, 8'h0C, 8'h07);
    put2(16'h0006, 8'h0D, 8'h07);
    put(16'h0008, 8'hFF);
    run(20);
    check(stall == 20, "R8 stall cycles", stall, 20);
    check(nouts == 2 && outs[0] == 16'hA5C3 && outs[1] == 16'hA5C3, "R8 input words",
          {outs[0], outs[1]}, 32'hA5C3A5C3);

    // R9: back-to-back outputs, one strobe each
    put4(16'h0000, 8'h01, 8'h01, 16'h1111);
    put4(16'h0004, 8'h01, 8'h02, 16'h2222);
    put2(16'h0008, 8'h0D, 8'h01);
    put2(16'h000A, 8'h0D, 8'h02);
    put2(16'h000C, 8'h0D, 8'h01);
    put(16'h000E, 8'hFF);
    run(0);
    check(nouts == 3, "R9 strobe count", nouts, 3);
    check(outs[0] == 16'h1111 && outs[1] == 16'h2222 && outs[2] == 16'h1111, "R9 output order",
          {outs[0], outs[1]}, 32'h11112222);

    // R10: halt first, later output never appears
    put(16'h0000, 8'hFF);
    put2(16'h0001, 8'h0D, 8'h00);
    run(0);
    check(hc >= 8, "R10 halted held", hc, 8);
    check(nouts == 0 && bad == 0, "R10 quiet after halt", {nouts[15:0], bad[15:0]}, 0);
    check(!halted, "R10 reset clears halt", halted, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule